// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Scheduler

This block keeps a single-rank SDRAM alive and saves power while the memory is idle. A programmable down-counter sets the number of clock cycles between refreshes. Each expiry queues one refresh, which the block runs as a precharge-all followed by an auto-refresh, with the precharge and refresh-cycle spacings kept. No refresh address is produced, because the memory steps its own row pointer. If a new refresh request arrives while the previous one is still waiting to start, a sticky error interrupt is raised. Reading the status clears it.

A single master raises a request level to reach the memory. The block holds that master on a wait line while a refresh or a low-power exit is under way. Once the master has been idle for a programmable number of cycles, the block enters one of three selectable low-power states: self-refresh, power-down or deep power-down. A later request leaves the state again with the matching exit command. In power-down the block still owns refresh: a due refresh wakes the device, refreshes it and lets it fall back. All commands go out as abstract one-cycle codes to a downstream command sequencer.

Top module: `sdr_refresh_sched`

## Requirements
- R1: With a refresh interval N > 0 and the block awake and free, consecutive precharge-all commands (code 1) are exactly N cycles apart.
- R2: A refresh interval of 0 stops the refresh timer. No command code other than 0 (idle) is issued and the error interrupt stays low.
- R3: A refresh is a precharge-all (code 1) followed by an auto-refresh (code 2) exactly T_RP cycles later. No new command that could open a row follows within T_RC cycles of the auto-refresh.
- R4: mst_wait is high only while mst_req is high. It stays high from the auto-refresh cycle until exactly T_RC cycles after it, and it is low when the block is awake with no refresh queued.
- R5: When a refresh request arrives while the previous one has not yet started, irq_rfsh_err goes high and stays high.
- R6: A one-cycle pulse on stat_rd clears irq_rfsh_err on the next cycle, unless a new error occurs in that same cycle.
- R7: Low-power mode 0 never enters a low-power state.
- R8: In mode 1 (self-refresh, entry code 3) or mode 2 (power-down, entry code 5), with idle timeout T, the entry command appears T+1 cycles after the first cycle in which mst_req is low.
- R9: Mode 3 (deep power-down, entry code 7, exit code 8) ignores the idle timeout and enters one cycle after the first idle cycle.
- R10: In self-refresh the block issues no refresh commands, queues no refresh and raises no error.
- R11: In power-down a due refresh issues power-down exit (code 6). Precharge-all follows T_RP+1 cycles later, then the auto-refresh, then power-down entry again T_RC+1 cycles after the auto-refresh when the idle timeout has already run out.
- R12: A request in a low-power state issues that state's exit code (4 for self-refresh, 6 for power-down, 8 for deep power-down) in the next cycle. mst_wait stays high for exactly T_RP cycles from the exit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IW | Cycles between refreshes; 0 stops the timer |
| cfg_lp_mode | input | 2 | 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_idle_tmo | input | TW | Idle cycles before self-refresh or power-down entry |
| mst_req | input | 1 | Master wants the memory (level, held until served) |
| mst_wait | output | 1 | Master must hold its access |
| stat_rd | input | 1 | One-cycle read of the status; clears the error |
| irq_rfsh_err | output | 1 | Sticky missed-refresh interrupt |
| cmd_code | output | 4 | Command to the sequencer, one cycle each, 0 = idle |

## Verification
The assertions assume that the master keeps mst_req high until mst_wait falls, and that stat_rd is a single-cycle pulse. They also assume that the configuration inputs change only while no refresh or exit sequence depends on them. The bench drives every input at the falling edge and changes configuration only between phases. It lets sequences drain before it switches modes or reads the status. Random refresh intervals are drawn at 12 or more, so the awake gap of R1 is never hidden by a running sequence. The error case alone uses an interval shorter than the sequence on purpose.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_PRE_ALL   = 4'd1,
    CMD_AUTO_REF  = 4'd2,
    CMD_SR_ENTER  = 4'd3,
    CMD_SR_EXIT   = 4'd4,
    CMD_PD_ENTER  = 4'd5,
    CMD_PD_EXIT   = 4'd6,
    CMD_DPD_ENTER = 4'd7,
    CMD_DPD_EXIT  = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    LP_OFF   = 2'd0,
    LP_SELF  = 2'd1,
    LP_PWRDN = 2'd2,
    LP_DEEP  = 2'd3
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_PRE_W,
    ST_REF_W,
    ST_SELF,
    ST_PWRDN,
    ST_DEEP,
    ST_EXIT_W
  } seq_st_e;

  function automatic cmd_e lp_enter_code(input lp_mode_e m);
    case (m)
      LP_SELF:  return CMD_SR_ENTER;
      LP_PWRDN: return CMD_PD_ENTER;
      LP_DEEP:  return CMD_DPD_ENTER;
      default:  return CMD_NOP;
    endcase
  endfunction

  function automatic seq_st_e lp_state(input lp_mode_e m);
    case (m)
      LP_SELF:  return ST_SELF;
      LP_PWRDN: return ST_PWRDN;
      LP_DEEP:  return ST_DEEP;
      default:  return ST_ACTIVE;
    endcase
  endfunction

  function automatic cmd_e lp_exit_code(input seq_st_e s);
    case (s)
      ST_SELF:  return CMD_SR_EXIT;
      ST_PWRDN: return CMD_PD_EXIT;
      ST_DEEP:  return CMD_DPD_EXIT;
      default:  return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdr_rfsh_timer.sv
module sdr_rfsh_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval,
  output logic          tick
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (interval == '0)     cnt <= '0;
    else if (cnt <= ONE)         cnt <= interval;
    else                         cnt <= cnt - ONE;
  end

  assign tick = (interval != '0) && (cnt == ONE);
endmodule

// File: rtl/sdr_idle_timer.sv
module sdr_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          deep,
  input  logic [TW-1:0] tmo,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (busy)       cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + TW'(1);
  end

  assign expired = !busy && (deep || (cnt >= tmo));
endmodule

// File: rtl/sdr_lp_seq.sv
module sdr_lp_seq
  import sdr_sched_pkg::*;
#(
  parameter int T_RP = 3,
  parameter int T_RC = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rf_pend,
  input  logic     mst_req,
  input  lp_mode_e lp_mode,
  input  logic     idle_ok,
  output cmd_e     cmd,
  output logic     rf_issue,
  output logic     ready,
  output logic     lp_mask,
  output logic     in_self
);
  localparam int MAXW = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int WW   = $clog2(MAXW + 1);
  localparam logic [WW-1:0] RP_LD = WW'(T_RP - 1);
  localparam logic [WW-1:0] RC_LD = WW'(T_RC - 1);

  seq_st_e       st;
  logic [WW-1:0] wcnt;
  cmd_e          cmd_q;
  logic          lp_enter, lp_exit, in_lp;

  always_comb begin
    in_lp    = (st == ST_SELF) || (st == ST_PWRDN) || (st == ST_DEEP);
    rf_issue = (st == ST_ACTIVE) && rf_pend;
    ready    = (st == ST_ACTIVE) && !rf_pend;
    lp_enter = ready && !mst_req && (lp_mode != LP_OFF) && idle_ok;
    lp_exit  = in_lp && (mst_req || ((st == ST_PWRDN) && rf_pend));
    lp_mask  = (st == ST_SELF) || (st == ST_DEEP);
    in_self  = (st == ST_SELF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_ACTIVE;
      wcnt  <= '0;
      cmd_q <= CMD_NOP;
    end else begin
      cmd_q <= CMD_NOP;
      case (st)
        ST_ACTIVE: begin
          if (rf_issue) begin
            cmd_q <= CMD_PRE_ALL;
            st    <= ST_PRE_W;
            wcnt  <= RP_LD;
          end else if (lp_enter) begin
            cmd_q <= lp_enter_code(lp_mode);
            st    <= lp_state(lp_mode);
          end
        end
        ST_PRE_W: begin
          if (wcnt == '0) begin
            cmd_q <= CMD_AUTO_REF;
            st    <= ST_REF_W;
            wcnt  <= RC_LD;
          end else wcnt <= wcnt - WW'(1);
        end
        ST_REF_W, ST_EXIT_W: begin
          if (wcnt == '0) st <= ST_ACTIVE;
          else            wcnt <= wcnt - WW'(1);
        end
        ST_SELF, ST_PWRDN, ST_DEEP: begin
          if (lp_exit) begin
            cmd_q <= lp_exit_code(st);
            st    <= ST_EXIT_W;
            wcnt  <= RP_LD;
          end
        end
        default: st <= ST_ACTIVE;
      endcase
    end
  end

  assign cmd = cmd_q;
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
  import sdr_sched_pkg::*;
#(
  parameter int IW   = 16,
  parameter int TW   = 16,
  parameter int T_RP = 3,
  parameter int T_RC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cfg_interval,
  input  logic [1:0]    cfg_lp_mode,
  input  logic [TW-1:0] cfg_idle_tmo,
  input  logic          mst_req,
  output logic          mst_wait,
  input  logic          stat_rd,
  output logic          irq_rfsh_err,
  output logic [3:0]    cmd_code
);
  lp_mode_e mode;
  logic     rf_tick, rf_tick_eff, rf_pend, rf_issue, err_set;
  logic     idle_ok, seq_ready, seq_mask, seq_self;
  cmd_e     seq_cmd;

  assign mode = lp_mode_e'(cfg_lp_mode);

  sdr_rfsh_timer #(.IW(IW)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .interval(cfg_interval), .tick(rf_tick)
  );

  sdr_idle_timer #(.TW(TW)) u_itmr (
    .clk(clk), .rst_n(rst_n), .busy(mst_req), .deep(mode == LP_DEEP),
    .tmo(cfg_idle_tmo), .expired(idle_ok)
  );

  sdr_lp_seq #(.T_RP(T_RP), .T_RC(T_RC)) u_seq (
    .clk(clk), .rst_n(rst_n), .rf_pend(rf_pend), .mst_req(mst_req),
    .lp_mode(mode), .idle_ok(idle_ok), .cmd(seq_cmd), .rf_issue(rf_issue),
    .ready(seq_ready), .lp_mask(seq_mask), .in_self(seq_self)
  );

  assign rf_tick_eff = rf_tick && !seq_mask;
  assign err_set     = rf_tick_eff && rf_pend && !rf_issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_pend      <= 1'b0;
      irq_rfsh_err <= 1'b0;
    end else begin
      if (rf_tick_eff)   rf_pend <= 1'b1;
      else if (rf_issue) rf_pend <= 1'b0;
      if (err_set)       irq_rfsh_err <= 1'b1;
      else if (stat_rd)  irq_rfsh_err <= 1'b0;
    end
  end

  assign mst_wait = mst_req && !seq_ready;
  assign cmd_code = seq_cmd;
endmodule

// File: rtl/sdr_sched_chk.sv
module sdr_sched_chk
  import sdr_sched_pkg::*;
#(
  parameter int T_RP = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd_code,
  input logic [1:0] cfg_lp_mode,
  input logic       mst_req,
  input logic       mst_wait,
  input logic       stat_rd,
  input logic       irq_rfsh_err,
  input logic       rf_tick,
  input logic       rf_pend,
  input logic       seq_self
);
  logic [7:0] since_pre;

  always_ff @(posedge clk) begin
    if (!rst_n)                    since_pre <= '0;
    else if (cmd_code == CMD_PRE_ALL) since_pre <= 8'd1;
    else if (since_pre != 8'hff)   since_pre <= since_pre + 8'd1;
  end

  p_pre_to_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_AUTO_REF) |-> (since_pre == 8'(T_RP)));

  p_wait_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_wait |-> mst_req);

  p_wait_in_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_AUTO_REF) && mst_req) |-> mst_wait);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rfsh_err) |-> $past(rf_tick));

  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rfsh_err && stat_rd && !rf_tick) |=> !irq_rfsh_err);

  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_SR_ENTER) || (cmd_code == CMD_PD_ENTER) ||
     (cmd_code == CMD_DPD_ENTER)) |-> ($past(cfg_lp_mode) != 2'd0));

  p_no_queue_in_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_self && $past(seq_self)) |-> !rf_pend);
endmodule

bind sdr_refresh_sched sdr_sched_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cfg_lp_mode(cfg_lp_mode),
  .mst_req(mst_req), .mst_wait(mst_wait), .stat_rd(stat_rd),
  .irq_rfsh_err(irq_rfsh_err), .rf_tick(rf_tick), .rf_pend(rf_pend),
  .seq_self(seq_self)
);

// File: tb/sdr_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdr_refresh_sched_tb;
  localparam int IW = 16, TW = 16, T_RP = 3, T_RC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] cfg_interval;
  logic [1:0]    cfg_lp_mode;
  logic [TW-1:0] cfg_idle_tmo;
  logic          mst_req, stat_rd;
  logic          mst_wait, irq_rfsh_err;
  logic [3:0]    cmd_code;
  int            cyc = 0;
  int            tests = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_refresh_sched #(.IW(IW), .TW(TW), .T_RP(T_RP), .T_RC(T_RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .cfg_lp_mode(cfg_lp_mode), .cfg_idle_tmo(cfg_idle_tmo),
    .mst_req(mst_req), .mst_wait(mst_wait), .stat_rd(stat_rd),
    .irq_rfsh_err(irq_rfsh_err), .cmd_code(cmd_code)
  );

  function automatic int exp_entry(input int tmo, input bit deep);
    return deep ? 1 : tmo + 1;
  endfunction
  function automatic int exp_gap(input int n);
    return n;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cmd(input logic [3:0] c, input int lim, output int n);
    n = 0;
    while (cmd_code !== c && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, bad, t0, t1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_interval = '0; cfg_lp_mode = 2'd0; cfg_idle_tmo = '0;
    mst_req = 1'b0; stat_rd = 1'b0;
    step(4);
    chk("R3 reset cmd", int'(cmd_code), 0);
    chk("R4 reset wait", int'(mst_wait), 0);
    chk("R5 reset irq", int'(irq_rfsh_err), 0);
    rst_n = 1'b1;

    // R2: timer stopped
    bad = 0;
    for (int i = 0; i < 100; i++) begin step(1); if (cmd_code != 0) bad++; end
    chk("R2 no commands", bad, 0);
    chk("R2 no error", int'(irq_rfsh_err), 0);

    // R4 random requests while awake and free
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      mst_req = 1'($urandom % 2);
      step(1);
      if (mst_wait !== 1'b0) bad++;
    end
    chk("R4 no wait when free", bad, 0);
    mst_req = 1'b0;

    // R1 / R3 / R4 directed
    cfg_interval = 16'd20;
    wait_cmd(4'd1, 100, n);
    t0 = cyc;
    mst_req = 1'b1;
    step(1); wait_cmd(4'd2, 20, n);
    chk("R3 precharge to refresh", cyc - t0, T_RP);
    chk("R4 wait at refresh", int'(mst_wait), 1);
    n = 0;
    while (mst_wait && n < 50) begin step(1); n++; end
    chk("R3 R4 wait span after refresh", n, T_RC);
    wait_cmd(4'd1, 100, n);
    chk("R1 gap 20", cyc - t0, exp_gap(20));
    mst_req = 1'b0;

    for (int k = 0; k < 3; k++) begin
      int iv;
      iv = 12 + int'($urandom % 30);
      cfg_interval = 16'(iv);
      step(1); wait_cmd(4'd1, 200, n);
      step(1); wait_cmd(4'd1, 200, n);
      t1 = cyc;
      step(1); wait_cmd(4'd1, 200, n);
      chk("R1 random gap", cyc - t1, exp_gap(iv));
    end

    // R5 / R6
    cfg_interval = '0; step(20);
    cfg_interval = 16'd5;
    n = 0;
    while (!irq_rfsh_err && n < 60) begin step(1); n++; end
    chk("R5 error raised", int'(irq_rfsh_err), 1);
    cfg_interval = '0; step(20);
    chk("R6 error sticky", int'(irq_rfsh_err), 1);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R6 cleared by read", int'(irq_rfsh_err), 0);

    // R7
    bad = 0;
    for (int i = 0; i < 60; i++) begin step(1); if (cmd_code != 0) bad++; end
    chk("R7 mode off stays awake", bad, 0);

    // R8 self-refresh timeout, then R12 exit
    cfg_lp_mode = 2'd1;
    for (int k = 0; k < 3; k++) begin
      int tm;
      tm = (k == 0) ? 0 : int'($urandom % 20);
      cfg_idle_tmo = 16'(tm);
      mst_req = 1'b1; step(8);
      mst_req = 1'b0;
      wait_cmd(4'd3, 100, n);
      chk("R8 entry delay", n, exp_entry(tm, 1'b0));
    end
    mst_req = 1'b1; step(1);
    chk("R12 self-refresh exit code", int'(cmd_code), 4);
    n = 0;
    while (mst_wait && n < 50) begin step(1); n++; end
    chk("R12 exit latency", n, T_RP);
    mst_req = 1'b0;

    // R10 self-refresh with timer running
    cfg_idle_tmo = '0; cfg_interval = 16'd15;
    wait_cmd(4'd3, 100, n);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      step(1);
      if (cmd_code != 0 || irq_rfsh_err) bad++;
    end
    chk("R10 silent self-refresh", bad, 0);
    cfg_interval = '0;

    // R9 deep power-down ignores timeout
    cfg_lp_mode = 2'd3; cfg_idle_tmo = 16'd25;
    mst_req = 1'b1; step(8); mst_req = 1'b0;
    wait_cmd(4'd7, 100, n);
    chk("R9 deep entry delay", n, exp_entry(25, 1'b1));
    mst_req = 1'b1; step(1);
    chk("R9 R12 deep exit code", int'(cmd_code), 8);
    step(8); mst_req = 1'b0;

    // R11 power-down refresh round trip
    cfg_lp_mode = 2'd2; cfg_idle_tmo = '0; cfg_interval = 16'd30;
    wait_cmd(4'd5, 100, n);
    step(1); wait_cmd(4'd6, 100, n);
    t0 = cyc;
    wait_cmd(4'd1, 20, n);
    chk("R11 exit to precharge", cyc - t0, T_RP + 1);
    t0 = cyc;
    step(1); wait_cmd(4'd2, 20, n);
    chk("R11 precharge to refresh", cyc - t0, T_RP);
    t0 = cyc;
    step(1); wait_cmd(4'd5, 30, n);
    chk("R11 refresh to re-entry", cyc - t0, T_RC + 1);
    cfg_interval = '0; step(50);
    mst_req = 1'b1; step(1);
    chk("R12 power-down exit code", int'(cmd_code), 6);
    step(6); mst_req = 1'b0; step(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule